// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block produces the black-level clamp enable for a three-channel video digitizer front end. It runs on the pixel clock. The horizontal sync input is first brought to a common active-high sense under a polarity control. The end of each sync pulse then starts a two-stage timer. That timer waits a programmable placement count and then holds the clamp for a programmable duration. In this way the clamp lands on the back porch and never on the blacker-than-black sync tip. A typical line uses a placement of 4 and a duration of 40 pixel clocks.

A source-select input can bypass the timer. The clamp then follows an externally timed clamp signal, which is synchronized to the pixel clock and corrected for its polarity. Each channel has a level-select bit. The clamp is steered to either a midscale strobe or a ground strobe for that channel, so that color-difference channels can clamp to mid-code while luma clamps to zero.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While rst_ni is low and after its release, with internal source selected, clamp_o and all per-channel strobes are 0 until a sync trailing edge has been timed.
- R2: The normalized sync is active when hsync_i equals hsync_pol_i. A trailing edge is seen at clock edge k when the normalized sync was active at edge k-1 and inactive at edge k. With placement P captured from place_i, the internal clamp first asserts in the cycle that follows edge k+P+2.
- R3: The internal clamp stays asserted for exactly D cycles, where D is captured from dur_i. It covers the cycles after edges k+P+2 through k+P+1+D.
- R4: A duration of 0 produces no clamp for that line, for any placement.
- R5: A trailing edge at edge k that arrives during a placement or clamp window lets the old window run through the cycle after edge k. From edge k+1 on, timing restarts from the new edge as in R2 and R3.
- R6: With hsync_pol_i=0 the sync is treated as active-low. The same timing applies from the rising edge of hsync_i.
- R7: With clamp_src_i=1, clamp_o in the cycle after edge k equals the ext_clamp_i value sampled at edge k-1. The value is taken as is when ext_pol_i=1 and inverted when ext_pol_i=0. clamp_src_i and ext_pol_i take effect without delay.
- R8: For each channel c, mid_clamp_o[c] = clamp_o AND lvl_mid_i[c], and gnd_clamp_o[c] = clamp_o AND NOT lvl_mid_i[c]. Bit c=0 is the first channel.
- R9: place_i and dur_i are captured at edge k+1 after the trailing edge. Changes after that edge do not alter the current line's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync |
| hsync_pol_i | input | 1 | 1: sync active high, 0: active low |
| ext_clamp_i | input | 1 | External clamp, asynchronous |
| ext_pol_i | input | 1 | 1: external clamp active high, 0: active low |
| clamp_src_i | input | 1 | 1: external clamp drives output, 0: internal timer |
| place_i | input | 8 | Pixel clocks from sync trailing edge to clamp start |
| dur_i | input | 8 | Clamp length in pixel clocks |
| lvl_mid_i | input | 3 | Per-channel level select, 1 midscale, 0 ground |
| clamp_o | output | 1 | Clamp enable |
| mid_clamp_o | output | 3 | Per-channel midscale clamp strobe |
| gnd_clamp_o | output | 3 | Per-channel ground clamp strobe |

## Verification
The typical 4/40 setting, a zero placement with a one-cycle clamp, and a zero duration are each run over several lines. Together they separate off-by-one placement errors from errors in the duration count. A second sync pulse is inserted in the middle of a clamp window, which shows whether the timer restarts or finishes the old window. A run with active-low sync shows that the rising input edge is taken as the trailing edge. Changing placement and duration mid-line shows when the values are captured. Toggling the external clamp under both polarities, while the source select switches, checks the synchronizer lag, the inversion and the immediate bypass. Changing level-select patterns shows the steering of each channel.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PLACE = 2'd1,
    PH_CLAMP = 2'd2
  } phase_e;
endpackage

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic pol_i,
  output logic trail_o
);
  logic act, act_q, trail_q;

  assign act = pol_i ? sync_i : ~sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      act_q   <= act;
      trail_q <= act_q & ~act;
    end
  end

  assign trail_o = trail_q;

  // R2
  no_double_trail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_q |=> !trail_q);
  // R6
  trail_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_q |-> !act_q);
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trail_i,
  input  logic [CW-1:0] place_i,
  input  logic [CW-1:0] dur_i,
  output logic          clamp_o
);
  import clamp_pkg::*;

  phase_e        phase_q;
  logic [CW-1:0] pcnt_q, dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      dcnt_q  <= '0;
    end else if (trail_i) begin
      // new line: restart even mid-window
      phase_q <= PH_PLACE;
      pcnt_q  <= place_i;
      dcnt_q  <= dur_i;
    end else begin
      unique case (phase_q)
        PH_PLACE: begin
          if (pcnt_q == '0) phase_q <= (dcnt_q == '0) ? PH_IDLE : PH_CLAMP;
          else              pcnt_q  <= pcnt_q - CW'(1);
        end
        PH_CLAMP: begin
          if (dcnt_q == CW'(1)) phase_q <= PH_IDLE;
          else                  dcnt_q  <= dcnt_q - CW'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign clamp_o = (phase_q == PH_CLAMP);

  // R3
  clamp_from_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_o) |-> $past(phase_q == PH_PLACE));
  // R4
  clamp_cnt_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CLAMP) |-> (dcnt_q != '0));
  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_i |=> (phase_q == PH_PLACE));
endmodule

// File: rtl/clamp_ext_sync.sv
module clamp_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic pol_i,
  output logic clamp_o
);
  logic [STAGES-1:0] q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[s] <= 1'b0;
      else         q[s] <= (s == 0) ? ext_i : q[(s == 0) ? 0 : s-1];
    end
  end

  assign clamp_o = pol_i ? q[STAGES-1] : ~q[STAGES-1];
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int CW          = 8,
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hsync_i,
  input  logic           hsync_pol_i,
  input  logic           ext_clamp_i,
  input  logic           ext_pol_i,
  input  logic           clamp_src_i,
  input  logic [CW-1:0]  place_i,
  input  logic [CW-1:0]  dur_i,
  input  logic [NCH-1:0] lvl_mid_i,
  output logic           clamp_o,
  output logic [NCH-1:0] mid_clamp_o,
  output logic [NCH-1:0] gnd_clamp_o
);
  logic trail, int_clamp, ext_clamp;

  clamp_sync_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (hsync_i),
    .pol_i  (hsync_pol_i),
    .trail_o(trail)
  );

  clamp_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trail_i(trail),
    .place_i(place_i),
    .dur_i  (dur_i),
    .clamp_o(int_clamp)
  );

  clamp_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clamp_i),
    .pol_i  (ext_pol_i),
    .clamp_o(ext_clamp)
  );

  assign clamp_o = clamp_src_i ? ext_clamp : int_clamp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign mid_clamp_o[c] = clamp_o &  lvl_mid_i[c];
    assign gnd_clamp_o[c] = clamp_o & ~lvl_mid_i[c];
  end
endmodule

// File: tb/clamp_pulse_gen_test.sv
`timescale 1ns/1ps
module clamp_pulse_gen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hs = 1'b0, hpol = 1'b1, ext = 1'b0, epol = 1'b1, src = 1'b0;
  logic [7:0] place = 8'd4, dur = 8'd40;
  logic [2:0] sel = 3'b000;
  logic clamp;
  logic [2:0] mid, gnd;
  int checks = 0, fails = 0, cyc = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  clamp_pulse_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .hsync_pol_i(hpol),
    .ext_clamp_i(ext), .ext_pol_i(epol), .clamp_src_i(src),
    .place_i(place), .dur_i(dur), .lvl_mid_i(sel),
    .clamp_o(clamp), .mid_clamp_o(mid), .gnd_clamp_o(gnd)
  );

  // behavioural reference
  int age = -1, nage, cp = 0, cd = 0;
  bit prev_act = 0, a_now, e_last = 0, e_s2 = 0, exp_int = 0, trail;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age = -1; prev_act = 0; e_last = 0; e_s2 = 0; exp_int = 0; cp = 0; cd = 0;
    end else begin
      a_now = (hs == hpol);
      trail = prev_act && !a_now;
      prev_act = a_now;
      nage = (age >= 0 && age < 100000) ? age + 1 : age;
      if (nage == 1) begin cp = place; cd = dur; end
      exp_int = (nage >= 1) && (nage >= cp + 2) && (nage <= cp + 1 + cd);
      age = trail ? 0 : nage;
      e_s2 = e_last;
      e_last = ext;
    end
  end

  always @(negedge clk) begin
    bit ec;
    logic [2:0] em, eg;
    cyc++;
    ec = src ? (epol ? e_s2 : !e_s2) : exp_int;
    em = {3{ec}} & sel;
    eg = {3{ec}} & ~sel;
    checks++;
    if (clamp !== ec) begin
      fails++;
      $display("FAIL %s clamp_o cyc=%0d act=%b exp=%b", req, cyc, clamp, ec);
    end
    checks++;
    if (mid !== em || gnd !== eg) begin
      fails++;
      $display("FAIL R8 strobes cyc=%0d act=%b/%b exp=%b/%b", cyc, mid, gnd, em, eg);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog cyc=%0d act=running exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic line(input int act_n, input int idle_n);
    hs = hpol; idle(act_n);
    hs = ~hpol; idle(idle_n);
  endtask

  initial begin
    // R1: reset state
    hs = ~hpol;
    idle(4);
    rst_n = 1'b1;
    idle(10);
    // R2 R3: typical placement 4, duration 40
    req = "R2_R3"; sel = 3'b101;
    repeat (3) line(8, 90);
    // R3: zero placement, one-cycle clamp
    req = "R3"; place = 8'd0; dur = 8'd1; sel = 3'b010;
    repeat (3) line(3, 20);
    place = 8'd255; dur = 8'd255;
    line(2, 600);
    // R4: zero duration
    req = "R4"; place = 8'd2; dur = 8'd0;
    repeat (2) line(5, 40);
    place = 8'd0; line(5, 20);
    // R5: retrigger inside clamp and inside placement
    req = "R5"; place = 8'd10; dur = 8'd20; sel = 3'b111;
    line(4, 15); line(2, 5); line(1, 60);
    // R6: active-low sync
    req = "R6"; hpol = 1'b0; hs = 1'b1; idle(5);
    place = 8'd3; dur = 8'd5; sel = 3'b001;
    repeat (3) line(6, 25);
    hpol = 1'b1; hs = 1'b0; idle(10);
    // R9: change values mid-line
    req = "R9"; place = 8'd6; dur = 8'd12;
    line(4, 3); place = 8'd1; dur = 8'd2; idle(40);
    line(4, 30);
    // R7: external source, both polarities
    req = "R7"; src = 1'b1;
    for (int i = 0; i < 200; i++) begin
      ext = ((i * 7) % 5) < 2;
      if (i == 100) epol = 1'b0;
      if (i % 37 == 0) sel = sel + 3'd3;
      idle(1);
    end
    src = 1'b0; place = 8'd4; dur = 8'd40; req = "R7_R8";
    line(3, 20); src = 1'b1; idle(10); src = 1'b0; idle(40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule